// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic core of a small 8-bit RISC processor. Each cycle the decoder presents one opcode, two operands (a register pair, or a register and an immediate that the decoder has already placed on the second operand bus), and a bit index. The block answers with an 8-bit result in the same cycle. When the operation is marked valid, it also updates its internal status flags on the next rising clock edge, so the next instruction can use them.

The status byte holds carry, zero, negative, two's-complement overflow, sign (negative xor overflow), nibble half-carry and a one-bit transfer register. Bit-store copies a selected operand bit into the transfer bit. Bit-load writes the transfer bit into a selected bit of the operand and returns that as the result. The global interrupt-enable bit is not kept in the block: it is shown in the status byte exactly as it arrives on its input pin.

Top module: `alu8_core`

## Requirements
- R1: The opcode encoding is ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, EOR=6, COM=7, NEG=8, INC=9, DEC=10, LSR=11, ROR=12, ASR=13, BST=14, BLD=15. `result_o` is combinational in the same cycle, and the flags take effect at the rising edge on which `op_valid` is high.
- R2: `status_o` bit layout: C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Bit 7 always equals `int_en_i`, with no register between them.
- R3: Every operation other than BST and BLD sets N to bit 7 of its result.
- R4: Every operation other than BST and BLD sets Z exactly when its result is 0x00.
- R5: Every operation other than BST and BLD sets S to N xor V.
- R6: ADD and ADC (ADC adds the stored C) set C to the carry out of bit 7 and H to the carry out of bit 3. They set V=(A7&B7&~R7)|(~A7&~B7&R7).
- R7: SUB, SBC (SBC also subtracts the stored C) and NEG (0 minus A) set C and H to the borrow out of bit 7 and out of bit 3. They set V=(A7&~B7&~R7)|(~A7&B7&R7), where NEG uses A=0 and B=operand.
- R8: AND, OR and EOR clear V and leave C and H unchanged. COM (bitwise invert) clears V, sets C to 1 and leaves H unchanged.
- R9: INC and DEC add or subtract one. They set V only on 0x7F→0x80 or 0x80→0x7F, and leave C and H unchanged.
- R10: LSR shifts in 0, ROR shifts in the old C, and ASR keeps bit 7. All three shift right by one, put the old bit 0 into C, set V to N xor C and leave H unchanged.
- R11: BST copies `opa[bit_sel]` into T and returns `opa`. BLD returns `opa` with bit `bit_sel` replaced by T. Neither touches C, Z, N, V, S or H, and only BST changes T.
- R12: When `op_valid` is low, bits 6:0 of `status_o` hold their value whatever the other inputs do.
- R13: A synchronous active-low reset clears bits 6:0 of the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Commit the flags of the current operation at the next edge |
| op_code | input | 4 | Operation select (R1 encoding) |
| opa | input | 8 | First operand / register being modified |
| opb | input | 8 | Second operand (register or immediate) |
| bit_sel | input | 3 | Bit index for BST and BLD |
| int_en_i | input | 1 | Global interrupt enable, passed to status bit 7 |
| result_o | output | 8 | Operation result, same cycle |
| status_o | output | 8 | Status byte (R2 layout) |

## Verification
The only internal state is the seven stored flag bits. A wrong flag is visible on `status_o` one edge after the operation that set it. When the wrong bit is C or T, it also appears in `result_o` on the next ADC, SBC, ROR or BLD that reads it. The vector walk chains operations so that each instruction depends on flags left by the one before. A stale or corrupted carry or transfer bit therefore shows up within one instruction. Directed steps check idle hold, reset clearing and the combinational interrupt bit.

// File: rtl/alu8_pkg.sv
// Shared opcode type and status bit positions for the 8-bit ALU.
// Assumes a 4-bit opcode field and an 8-bit status byte.
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
        OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_EOR = 4'd6,  OP_COM = 4'd7,
        OP_NEG = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_LSR = 4'd11,
        OP_ROR = 4'd12, OP_ASR = 4'd13, OP_BST = 4'd14, OP_BLD = 4'd15
    } alu_op_e;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;
endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor with carry-in. Produces result, carry or borrow out of the
// top bit, carry or borrow out of bit 3, and two's-complement overflow.
// Assumes DATA_W >= 5 so that a low nibble exists below the top bit.
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic              sub,
    input  logic              cin,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] r,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;
    logic [4:0]      nib;

    // Full-width and low-nibble sum or difference including carry/borrow in.
    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b} - (DATA_W+1)'(cin);
            nib  = {1'b0, a[3:0]} - {1'b0, b[3:0]} - 5'(cin);
        end else begin
            wide = {1'b0, a} + {1'b0, b} + (DATA_W+1)'(cin);
            nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + 5'(cin);
        end
    end

    assign r     = wide[MSB:0];
    assign c_out = wide[DATA_W];
    assign h_out = nib[4];

    // Overflow from operand and result sign bits, separately for add and subtract.
    always_comb begin
        if (sub)
            v_out = (a[MSB] & ~b[MSB] & ~r[MSB]) | (~a[MSB] & b[MSB] & r[MSB]);
        else
            v_out = (a[MSB] & b[MSB] & ~r[MSB]) | (~a[MSB] & ~b[MSB] & r[MSB]);
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise and right-shift unit: AND, OR, EOR, COM, LSR, ROR, ASR.
// Produces the result and the bit shifted out (bit 0) as carry candidate.
// Assumes the caller ignores c_out for the non-shift operations.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic              cin,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] r,
    output logic              c_out
);
    localparam int MSB = DATA_W - 1;

    // Select the bitwise or shift result for the current opcode.
    always_comb begin
        c_out = a[0];
        case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_EOR:  r = a ^ b;
            OP_COM:  r = ~a;
            OP_LSR:  r = {1'b0, a[MSB:1]};
            OP_ROR:  r = {cin, a[MSB:1]};
            OP_ASR:  r = {a[MSB], a[MSB:1]};
            default: r = a;
        endcase
    end
endmodule

// File: rtl/alu8_bitxfer.sv
// Transfer-bit unit: extracts a selected operand bit (store) and inserts the
// transfer bit at a selected position (load). Assumes sel < DATA_W.
module alu8_bitxfer #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [SEL_W-1:0]  sel,
    input  logic              t_in,
    output logic              t_out,
    output logic [DATA_W-1:0] r
);
    // Pick the stored bit and build the loaded word.
    always_comb begin
        t_out  = a[sel];
        r      = a;
        r[sel] = t_in;
    end
endmodule

// File: rtl/alu8_core.sv
// Single-cycle ALU with registered status flags. The result is combinational.
// The flags C,Z,N,V,S,H,T are written at the edge where op_valid is high.
// Status bit 7 mirrors int_en_i. Assumes the decoder holds the inputs
// stable across the edge.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              int_en_i,
    output logic [DATA_W-1:0] result_o,
    output logic [7:0]        status_o
);
    localparam int MSB = DATA_W - 1;

    alu_op_e op;
    logic [6:0] flags_q, flags_d;
    logic c_q, t_q;

    logic              as_sub, as_cin;
    logic [DATA_W-1:0] as_a, as_b, as_r;
    logic              as_c, as_h, as_v;
    logic [DATA_W-1:0] lg_r, bx_r;
    logic              lg_c, bx_t;
    logic              res_n, res_z;

    assign op  = alu_op_e'(op_code);
    assign c_q = flags_q[FL_C];
    assign t_q = flags_q[FL_T];

    // Steer operands of the add/subtract unit per arithmetic opcode.
    always_comb begin
        as_a = opa; as_b = opb; as_sub = 1'b0; as_cin = 1'b0;
        case (op)
            OP_ADC: as_cin = c_q;
            OP_SUB: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = c_q; end
            OP_NEG: begin as_a = '0; as_b = opa; as_sub = 1'b1; end
            OP_INC: as_b = DATA_W'(1);
            OP_DEC: begin as_b = DATA_W'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .sub(as_sub), .cin(as_cin), .a(as_a), .b(as_b),
        .r(as_r), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .op(op), .cin(c_q), .a(opa), .b(opb), .r(lg_r), .c_out(lg_c)
    );

    alu8_bitxfer #(.DATA_W(DATA_W)) u_bitxfer (
        .a(opa), .sel(bit_sel), .t_in(t_q), .t_out(bx_t), .r(bx_r)
    );

    // Choose the result source by opcode group.
    always_comb begin
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_NEG, OP_INC, OP_DEC:          result_o = as_r;
            OP_BST:                          result_o = opa;
            OP_BLD:                          result_o = bx_r;
            default:                         result_o = lg_r;
        endcase
    end

    assign res_n = result_o[MSB];
    assign res_z = (result_o == '0);

    // Form the next flag set from the opcode's update rules.
    always_comb begin
        flags_d = flags_q;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                flags_d[FL_C] = as_c;
                flags_d[FL_H] = as_h;
                flags_d[FL_V] = as_v;
                flags_d[FL_S] = res_n ^ as_v;
            end
            OP_INC, OP_DEC: begin
                flags_d[FL_V] = as_v;
                flags_d[FL_S] = res_n ^ as_v;
            end
            OP_AND, OP_OR, OP_EOR: begin
                flags_d[FL_V] = 1'b0;
                flags_d[FL_S] = res_n;
            end
            OP_COM: begin
                flags_d[FL_C] = 1'b1;
                flags_d[FL_V] = 1'b0;
                flags_d[FL_S] = res_n;
            end
            OP_LSR, OP_ROR, OP_ASR: begin
                flags_d[FL_C] = lg_c;
                flags_d[FL_V] = res_n ^ lg_c;
                flags_d[FL_S] = lg_c;
            end
            OP_BST: flags_d[FL_T] = bx_t;
            default: ;
        endcase
        if (op != OP_BST && op != OP_BLD) begin
            flags_d[FL_N] = res_n;
            flags_d[FL_Z] = res_z;
        end
    end

    // Status register: clear on reset, load on a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n)        flags_q <= '0;
        else if (op_valid) flags_q <= flags_d;
    end

    assign status_o = {int_en_i, flags_q};

    // ---------------- assertions ----------------
    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op != OP_BST && op != OP_BLD)
        |=> status_o[FL_Z] == ($past(result_o) == '0));

    p_neg_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op != OP_BST && op != OP_BLD)
        |=> status_o[FL_N] == $past(result_o[MSB]));

    p_sign_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op != OP_BST && op != OP_BLD)
        |=> status_o[FL_S] == (status_o[FL_N] ^ status_o[FL_V]));

    p_logic_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_AND || op == OP_OR || op == OP_EOR))
        |=> !status_o[FL_V] && $stable(status_o[FL_C]) && $stable(status_o[FL_H]));

    p_incdec_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_INC || op == OP_DEC))
        |=> $stable(status_o[FL_C]) && $stable(status_o[FL_H]));

    p_bst_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_BST) |=> status_o[FL_T] == $past(opa[bit_sel]));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(status_o[6:0]));

    // R2: interrupt bit is a direct copy of its input.
    always_comb begin
        if (rst_n) p_ibit_pass_r2: assert (status_o[FL_I] == int_en_i);
    end
endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] opa = 8'd0, opb = 8'd0;
    logic [2:0] bit_sel = 3'd0;
    logic       int_en_i = 1'b1;
    logic [7:0] result_o, status_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb(opb), .bit_sel(bit_sel), .int_en_i(int_en_i),
        .result_o(result_o), .status_o(status_o)
    );

    // Vector: {op, a, b, sel, expected result, expected status after edge}.
    // Chained: each vector starts from the status left by the previous one, I=1.
    localparam int NV = 18;
    localparam logic [38:0] VEC [NV] = '{
        {4'd0,  8'h3A, 8'h48, 3'd0, 8'h82, 8'hAC},  // ADD: H,V,N
        {4'd0,  8'hFF, 8'h01, 3'd0, 8'h00, 8'hA3},  // ADD: C,H,Z
        {4'd1,  8'h10, 8'h20, 3'd0, 8'h31, 8'h80},  // ADC with C=1
        {4'd2,  8'h10, 8'h20, 3'd0, 8'hF0, 8'h95},  // SUB borrow
        {4'd3,  8'h50, 8'h10, 3'd0, 8'h3F, 8'hA0},  // SBC with C=1, half borrow
        {4'd4,  8'hF0, 8'h3C, 3'd0, 8'h30, 8'hA0},  // AND keeps H
        {4'd6,  8'h5A, 8'h5A, 3'd0, 8'h00, 8'hA2},  // EOR zero
        {4'd5,  8'h80, 8'h01, 3'd0, 8'h81, 8'hB4},  // OR negative
        {4'd7,  8'h0F, 8'h00, 3'd0, 8'hF0, 8'hB5},  // COM sets C
        {4'd8,  8'h80, 8'h00, 3'd0, 8'h80, 8'h8D},  // NEG 0x80 overflow
        {4'd9,  8'h7F, 8'h00, 3'd0, 8'h80, 8'h8D},  // INC overflow, C kept
        {4'd10, 8'h01, 8'h00, 3'd0, 8'h00, 8'h83},  // DEC to zero
        {4'd11, 8'h03, 8'h00, 3'd0, 8'h01, 8'h99},  // LSR
        {4'd12, 8'h02, 8'h00, 3'd0, 8'h81, 8'h8C},  // ROR with C=1
        {4'd13, 8'h84, 8'h00, 3'd0, 8'hC2, 8'h8C},  // ASR
        {4'd14, 8'h04, 8'h00, 3'd2, 8'h04, 8'hCC},  // BST bit2 -> T=1
        {4'd15, 8'h00, 8'h00, 3'd7, 8'h80, 8'hCC},  // BLD T into bit7
        {4'd0,  8'h80, 8'h80, 3'd0, 8'h00, 8'hDB}   // ADD: C,V,Z,S, T kept
    };

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:              return "R6";
            4'd2, 4'd3, 4'd8:        return "R7";
            4'd4, 4'd5, 4'd6, 4'd7:  return "R8";
            4'd9, 4'd10:             return "R9";
            4'd11, 4'd12, 4'd13:     return "R10";
            default:                 return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, check result, then status after the edge.
    task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic [2:0] sel, input logic [7:0] exp_r,
                          input logic [7:0] exp_s, input string req);
        @(negedge clk);
        op_code = op; opa = a; opb = b; bit_sel = sel; op_valid = 1'b1;
        #1 check({"R1 result ", req}, result_o, exp_r);
        @(posedge clk);
        #1 check({"R2/R3/R4/R5 status ", req}, status_o, exp_s);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R13 reset status", status_o, 8'h80);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [38:0] v;
            v = VEC[i];
            run_op(v[38:35], v[34:27], v[26:19], v[18:16], v[15:8], v[7:0], tag_of(v[38:35]));
        end

        // R12: idle cycle with an ADD pattern that would change every flag.
        @(negedge clk);
        op_code = 4'd0; opa = 8'h7F; opb = 8'h01; op_valid = 1'b0;
        #1 check("R12 idle result", result_o, 8'h80);
        @(posedge clk);
        #1 check("R12 idle hold", status_o, 8'hDB);

        // R2: interrupt bit follows its input without an edge.
        @(negedge clk) int_en_i = 1'b0;
        #1 check("R2 interrupt bit low", status_o, 8'h5B);
        int_en_i = 1'b1;

        // R11: BLD with T=1 into bit 0, status untouched.
        run_op(4'd15, 8'hF0, 8'h00, 3'd0, 8'hF1, 8'hDB, "R11 BLD bit0");

        // R13: mid-run reset clears T and all flags; BLD then loads zero.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 check("R13 reset clears", status_o, 8'h80);
        @(negedge clk) rst_n = 1'b1;
        run_op(4'd15, 8'hFF, 8'h00, 3'd4, 8'hEF, 8'h80, "R11 BLD after reset");

        // R10: ROR with C=0 shifts in zero.
        run_op(4'd12, 8'h01, 8'h00, 3'd0, 8'h00, 8'h9B, "R10 ROR C0");
        // R9: DEC 0x80 -> 0x7F overflow, C held at 1.
        run_op(4'd10, 8'h80, 8'h00, 3'd0, 8'h7F, 8'h99, "R9 DEC overflow");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule